// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block runs single read or write cycles on an external memory bus on behalf of a processor-side master. A cycle starts when the requester raises `req_valid` while the controller is idle and the device owns the bus (`bus_master` high). The address, direction and write data are registered and held on the bus for the whole cycle. `cyc_active` stays high for as long as the cycle lasts. It also serves as the busy flag that holds off further requests.

The length of each cycle is set by two things. The first is a programmed minimum count of wait states (`cfg_min_wait`), captured when the cycle starts. The second is an external acknowledge (`ext_ack`, active high) that can keep the cycle open for as long as it stays low. The cycle lasts whichever of the two is longer. A cycle programmed with zero wait states always takes one clock and never looks at acknowledge. Acknowledge passes straight through when `cfg_ack_sync` is 0. When `cfg_ack_sync` is 1, it first goes through a two-flop synchronizer. Acknowledge only counts while `bus_master` is high. When a cycle ends, `done` pulses for one clock. On a read, the bus data is latched into `rd_data` on the same edge.

The sequencer has four states:
- ST_IDLE: waiting for a request. It moves to ST_ADDR when a request is accepted.
- ST_ADDR: the first clock of every cycle. It returns to ST_IDLE (complete) when the wait count is zero. Otherwise it moves to ST_MINWAIT.
- ST_MINWAIT: one clock per programmed wait state. On the last wait clock it returns to ST_IDLE (complete) if acknowledge is seen. Otherwise it moves to ST_STRETCH.
- ST_STRETCH: it returns to ST_IDLE (complete) on the first edge that sees acknowledge.

Top module: `ext_bus_waitctl`

## Requirements
- R1: After reset, `cyc_active` and `done` are 0 and `rd_data` is 0.
- R2: A request with `req_valid`=1 and `bus_master`=1 is accepted on a clock edge where the controller is idle. From the next cycle, `cyc_active` is 1 and `bus_addr`, `bus_write` (1 = write) and `bus_wdata` show the request's values.
- R3: While `cyc_active` is 1, further requests are not accepted and `bus_addr` does not change. A request that is removed before the cycle ends never starts a cycle.
- R4: With `cfg_min_wait`=0, `cyc_active` is high for exactly 1 clock, whatever the acknowledge input does.
- R5: With `cfg_min_wait`=W>0, `cyc_active` is high for at least 1+W clocks. If acknowledge is already present, it is high for exactly 1+W clocks. An early acknowledge does not shorten the cycle.
- R6: If acknowledge is first seen on the edge E0+n, where E0 is the accepting edge and n > 1+W, the cycle completes on that edge. `cyc_active` is then high for n clocks.
- R7: With `cfg_ack_sync`=1, acknowledge is seen two edges later than it would be with `cfg_ack_sync`=0.
- R8: Requests and acknowledge are ignored while `bus_master` is 0. A cycle waiting for acknowledge stays open until acknowledge is present while `bus_master` is 1.
- R9: `done` is high for exactly one clock after the completing edge. A read loads `ext_rdata` into `rd_data` on that edge. A write leaves `rd_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_min_wait | input | WAIT_W (4) | Minimum wait states, captured at accept |
| cfg_ack_sync | input | 1 | 1 = synchronize acknowledge through two flops |
| bus_master | input | 1 | Device currently owns the external bus |
| req_valid | input | 1 | Cycle request |
| req_addr | input | ADDR_W (16) | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W (16) | Write data |
| cyc_active | output | 1 | Cycle in progress (also the busy flag) |
| bus_addr | output | ADDR_W (16) | Address driven to the bus |
| bus_write | output | 1 | Direction driven to the bus |
| bus_wdata | output | DATA_W (16) | Write data driven to the bus |
| ext_ack | input | 1 | External transfer acknowledge, active high |
| ext_rdata | input | DATA_W (16) | Read data from the bus |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | DATA_W (16) | Captured read data |

## Verification
`cyc_active` rises one clock after the accepting edge E0. It falls after the completing edge Ec. Ec is E0+1 for a zero-wait cycle and max(E0+1+W, first qualified acknowledge edge) otherwise. In synchronize mode, the qualified edge is the raw acknowledge edge plus two. `done` and `rd_data` are due right after Ec. For every cycle the driver computes this length and the expected read data, and pushes them into a queue. A monitor samples on the falling clock edge, counts active clocks and compares them against the queue when `done` shows, so each result is read half a clock after the edge that produced it.

// File: rtl/waitctl_pkg.sv
package waitctl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ADDR    = 2'd1,
        ST_MINWAIT = 2'd2,
        ST_STRETCH = 2'd3
    } bus_state_t;

endpackage

// File: rtl/wc_ack_front.sv
module wc_ack_front #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack_raw,
    input  logic sync_mode,
    input  logic bus_master,
    output logic ack_eff
);

    localparam int SW = $clog2(SYNC_STAGES + 1);

    logic ack_synced;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            logic stage_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q <= 1'b0;
                else        stage_q <= ack_raw;
            end
            assign ack_synced = stage_q;
        end else begin : g_chain
            logic [SYNC_STAGES-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[SYNC_STAGES-2:0], ack_raw};
            end
            assign ack_synced = chain_q[SYNC_STAGES-1];
        end
    endgenerate

    // acknowledge only qualifies while this device owns the bus
    assign ack_eff = bus_master && (sync_mode ? ack_synced : ack_raw);

    // edges since reset, for the latency check only
    logic [SW-1:0] settle_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          settle_q <= '0;
        else if (settle_q != SW'(SYNC_STAGES)) settle_q <= settle_q + 1'b1;
    end

    // R7
    sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode && bus_master && settle_q == SW'(SYNC_STAGES))
            |-> ack_eff == $past(ack_raw, SYNC_STAGES));

endmodule

// File: rtl/wc_wait_counter.sv
module wc_wait_counter #(
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    input  logic              dec,
    output logic              is_zero,
    output logic              is_last
);

    logic [WAIT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (load)              cnt_q <= load_val;
        else if (dec && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign is_zero = (cnt_q == '0);
    assign is_last = (cnt_q == WAIT_W'(1));

    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && is_zero) |=> is_zero);

endmodule

// File: rtl/wc_seq.sv
module wc_seq
    import waitctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       bus_master,
    input  logic       cnt_zero,
    input  logic       cnt_last,
    input  logic       ack_eff,
    output bus_state_t state,
    output logic       accept,
    output logic       complete,
    output logic       cnt_dec,
    output logic       cyc_active
);

    bus_state_t nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (req_valid && bus_master) nxt = ST_ADDR;
            ST_ADDR:    nxt = cnt_zero ? ST_IDLE : ST_MINWAIT;
            ST_MINWAIT: if (cnt_last) nxt = ack_eff ? ST_IDLE : ST_STRETCH;
            ST_STRETCH: if (ack_eff) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept     = 1'b0;
        complete   = 1'b0;
        cnt_dec    = 1'b0;
        cyc_active = 1'b1;
        unique case (state)
            ST_IDLE: begin
                cyc_active = 1'b0;
                accept     = req_valid && bus_master;
            end
            ST_ADDR:    complete = cnt_zero;
            ST_MINWAIT: begin
                cnt_dec  = !cnt_last;
                complete = cnt_last && ack_eff;
            end
            ST_STRETCH: complete = ack_eff;
            default:    cyc_active = 1'b0;
        endcase
    end

    // R4
    zero_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && cnt_zero) |=> state == ST_IDLE);

    // R5
    min_wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MINWAIT && !cnt_last) |=> state == ST_MINWAIT);

    // R6
    stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STRETCH && !ack_eff) |=> state == ST_STRETCH);

    // R8
    no_master_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !bus_master) |=> state == ST_IDLE);

    // R8
    no_master_stretch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_STRETCH && !bus_master) |=> state == ST_STRETCH);

endmodule

// File: rtl/wc_xfer_regs.sv
module wc_xfer_regs #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              complete,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] ext_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_write,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              done
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_addr  <= '0;
            bus_write <= 1'b0;
            bus_wdata <= '0;
            rd_data   <= '0;
            done      <= 1'b0;
        end else begin
            done <= complete;
            if (accept) begin
                bus_addr  <= req_addr;
                bus_write <= req_write;
                bus_wdata <= req_wdata;
            end
            if (complete && !bus_write) rd_data <= ext_rdata;
        end
    end

endmodule

// File: rtl/ext_bus_waitctl.sv
module ext_bus_waitctl
    import waitctl_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int WAIT_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WAIT_W-1:0] cfg_min_wait,
    input  logic              cfg_ack_sync,
    input  logic              bus_master,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              cyc_active,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_write,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              ext_ack,
    input  logic [DATA_W-1:0] ext_rdata,
    output logic              done,
    output logic [DATA_W-1:0] rd_data
);

    bus_state_t state;
    logic       ack_eff;
    logic       cnt_zero;
    logic       cnt_last;
    logic       accept;
    logic       complete;
    logic       cnt_dec;

    wc_ack_front #(.SYNC_STAGES(SYNC_STAGES)) u_ack (
        .clk        (clk),
        .rst_n      (rst_n),
        .ack_raw    (ext_ack),
        .sync_mode  (cfg_ack_sync),
        .bus_master (bus_master),
        .ack_eff    (ack_eff)
    );

    wc_wait_counter #(.WAIT_W(WAIT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (cfg_min_wait),
        .dec      (cnt_dec),
        .is_zero  (cnt_zero),
        .is_last  (cnt_last)
    );

    wc_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .bus_master (bus_master),
        .cnt_zero   (cnt_zero),
        .cnt_last   (cnt_last),
        .ack_eff    (ack_eff),
        .state      (state),
        .accept     (accept),
        .complete   (complete),
        .cnt_dec    (cnt_dec),
        .cyc_active (cyc_active)
    );

    wc_xfer_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .complete  (complete),
        .req_addr  (req_addr),
        .req_write (req_write),
        .req_wdata (req_wdata),
        .ext_rdata (ext_rdata),
        .bus_addr  (bus_addr),
        .bus_write (bus_write),
        .bus_wdata (bus_wdata),
        .rd_data   (rd_data),
        .done      (done)
    );

    // R2
    accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_active && req_valid && bus_master)
            |=> (cyc_active && bus_addr == $past(req_addr)));

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_active && $past(cyc_active)) |-> $stable(bus_addr));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    read_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) && !bus_write |-> rd_data == $past(ext_rdata));

    // R9
    write_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) && bus_write |-> $stable(rd_data));

endmodule

// File: tb/sim_ext_bus_waitctl.sv
module sim_ext_bus_waitctl;

    localparam logic [15:0] RD_MASK = 16'h5A3C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_min_wait = '0;
    logic        cfg_ack_sync = 1'b0;
    logic        bus_master = 1'b1;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        cyc_active;
    logic [15:0] bus_addr;
    logic        bus_write;
    logic [15:0] bus_wdata;
    logic        ext_ack = 1'b0;
    logic [15:0] ext_rdata;
    logic        done;
    logic [15:0] rd_data;

    int n_cmp = 0;
    int n_bad = 0;
    int run_len = 0;
    int clk_count = 0;
    bit ended = 0;
    logic [15:0] last_rd = '0;

    int          q_len[$];
    logic [15:0] q_rd[$];
    string       q_tag[$];

    always #10 clk = ~clk;

    assign ext_rdata = bus_addr ^ RD_MASK;

    ext_bus_waitctl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_min_wait(cfg_min_wait),
        .cfg_ack_sync(cfg_ack_sync), .bus_master(bus_master),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .req_wdata(req_wdata), .cyc_active(cyc_active), .bus_addr(bus_addr),
        .bus_write(bus_write), .bus_wdata(bus_wdata), .ext_ack(ext_ack),
        .ext_rdata(ext_rdata), .done(done), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string what, input int got, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", what, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // monitor: counts active clocks and compares each completion
    always @(negedge clk) begin
        if (rst_n && !ended) begin
            if (cyc_active) run_len++;
            if (done) begin
                if (q_len.size() == 0) begin
                    check(0, "R9 unexpected done", 1, 0);
                end else begin
                    int    el;
                    logic [15:0] er;
                    string tg;
                    el = q_len.pop_front();
                    er = q_rd.pop_front();
                    tg = q_tag.pop_front();
                    check(run_len == el, {tg, " cycle length"}, run_len, el);
                    check(rd_data == er, {"R9 rd_data after ", tg}, int'(rd_data), int'(er));
                end
                run_len = 0;
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        clk_count++;
        if (clk_count > 20000 && !ended) begin
            check(0, "watchdog expired", clk_count, 20000);
            finish_run();
        end
    end

    // driver: one cycle with acknowledge raised at edge E0+d (d>=1) and
    // bus_master low until edge E0+m
    task automatic run_cycle(input logic [15:0] a, input logic we, input logic [15:0] wd,
                             input int w, input logic sync, input int d, input int m,
                             input string tag);
        int lat, first, len;
        ext_ack    = 1'b0;
        bus_master = 1'b1;
        repeat (3) @(negedge clk);
        cfg_min_wait = 4'(w);
        cfg_ack_sync = sync;
        lat   = sync ? 2 : 0;
        first = (d + lat > m) ? d + lat : m;
        if (w == 0) len = 1;
        else        len = (1 + w > first) ? 1 + w : first;
        q_len.push_back(len);
        last_rd = we ? last_rd : (a ^ RD_MASK);
        q_rd.push_back(last_rd);
        q_tag.push_back(tag);
        req_valid = 1'b1; req_addr = a; req_write = we; req_wdata = wd;
        @(posedge clk);
        for (int k = 1; k < 200; k++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (k == 1) begin
                check(cyc_active == 1'b1, "R2 cyc_active after accept", int'(cyc_active), 1);
                check(bus_addr == a && bus_write == we && bus_wdata == wd,
                      "R2 bus address/direction/data", int'(bus_addr), int'(a));
            end
            if (!cyc_active) break;
            ext_ack    = (k >= d);
            bus_master = (k >= m);
        end
        ext_ack    = 1'b0;
        bus_master = 1'b1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(cyc_active == 1'b0 && done == 1'b0, "R1 reset cyc_active/done",
              int'({cyc_active, done}), 0);
        check(rd_data == 16'h0, "R1 reset rd_data", int'(rd_data), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: zero-wait cycles ignore acknowledge
        run_cycle(16'h1234, 1'b0, 16'h0000, 0, 1'b0, 1,   0, "R4");
        run_cycle(16'h2001, 1'b0, 16'h0000, 0, 1'b0, 100, 0, "R4");
        run_cycle(16'h3003, 1'b1, 16'hBEEF, 0, 1'b1, 100, 0, "R4");
        // R5: minimum wait with acknowledge already present
        run_cycle(16'h4100, 1'b0, 16'h0000, 3, 1'b0, 1, 0, "R5");
        run_cycle(16'h4200, 1'b1, 16'h55AA, 1, 1'b0, 1, 0, "R5");
        // R6: acknowledge stretches the cycle
        run_cycle(16'h5000, 1'b0, 16'h0000, 2, 1'b0, 6,  0, "R6");
        run_cycle(16'h5100, 1'b0, 16'h0000, 1, 1'b0, 10, 0, "R6");
        run_cycle(16'h5200, 1'b1, 16'h0F0F, 4, 1'b0, 5,  0, "R6");
        // R7: synchronized acknowledge adds two edges
        run_cycle(16'h6000, 1'b0, 16'h0000, 1, 1'b1, 1, 0, "R7");
        run_cycle(16'h6100, 1'b0, 16'h0000, 4, 1'b1, 1, 0, "R7");
        run_cycle(16'h6200, 1'b0, 16'h0000, 2, 1'b1, 5, 0, "R7");
        // R8: acknowledge ignored while not bus master
        run_cycle(16'h7000, 1'b0, 16'h0000, 1, 1'b0, 1, 5, "R8");
        run_cycle(16'h7100, 1'b0, 16'h0000, 2, 1'b1, 1, 6, "R8");

        // R3: request during an active cycle is held off
        ext_ack = 1'b1; cfg_min_wait = 4'd3; cfg_ack_sync = 1'b0;
        repeat (3) @(negedge clk);
        q_len.push_back(4);
        last_rd = 16'h8800 ^ RD_MASK;
        q_rd.push_back(last_rd);
        q_tag.push_back("R3");
        req_valid = 1'b1; req_addr = 16'h8800; req_write = 1'b0;
        @(posedge clk);
        @(negedge clk);
        req_addr = 16'h9900;
        @(negedge clk);
        check(cyc_active && bus_addr == 16'h8800, "R3 address held during cycle",
              int'(bus_addr), 16'h8800);
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 20 && cyc_active; k++) @(negedge clk);
        repeat (3) begin
            @(negedge clk);
            check(!cyc_active, "R3 held-off request started nothing", int'(cyc_active), 0);
        end
        ext_ack = 1'b0;

        // R8: no acceptance without bus mastership
        bus_master = 1'b0;
        req_valid = 1'b1; req_addr = 16'hA000;
        repeat (3) begin
            @(negedge clk);
            check(!cyc_active && !done, "R8 request ignored without mastership",
                  int'(cyc_active), 0);
        end
        req_valid = 1'b0;
        bus_master = 1'b1;
        repeat (3) @(negedge clk);

        check(q_len.size() == 0, "R9 all completions seen", q_len.size(), 0);
        finish_run();
    end

endmodule